// File: doc/BRIEF.md
# Pseudo-Write Command Sequence Detector

This block sits beside a nonvolatile-backed RAM and decides when a run of special write cycles forms a valid command. A command cycle is a pseudo-write, made while the nonvolatile enable, the chip enable and the write enable are all low. The outer interface logic decodes those pins into a one-cycle `cmd_wr` strobe. An ordinary RAM write, with nonvolatile enable high, is decoded into a separate `ram_wr` strobe. The detector compares each command cycle's address and data with a fixed unlock sequence.

Two unlock pairs must arrive in order. The first is address 155h with data AAh. The second is address 0AAh with data 55h. A third pair at address 155h then selects the command: data 33h starts a store, data CCh arms the automatic store, and data CDh disarms it. The recognised command appears as a single-cycle pulse on its own output. The store engine and the arm flag live elsewhere. While `busy` is high, a store or recall is running and command cycles are ignored.

Top module: `nv_cmd_detect`

## Requirements
- R1: After reset all three command outputs are low and the detector is at its idle step, so a lone third-step pair produces no pulse.
- R2: Only the ordered sequence 155h/AAh, then 0AAh/55h, then 155h/op on `cmd_wr` strobes leads to a command. Idle cycles between strobes do not disturb the sequence, and the first two steps give no pulse.
- R3: A third pair of 155h/33h raises `store_go` for exactly the cycle after the strobe's clock edge.
- R4: A third pair of 155h/CCh raises `autostore_arm` for the cycle after the strobe's clock edge.
- R5: A third pair of 155h/CDh raises `autostore_disarm` for the cycle after the strobe's clock edge.
- R6: Every command pulse lasts one cycle, and at most one output is high at a time. After a command the detector is idle again, so a repeated op pair alone does nothing.
- R7: A command cycle that does not match the expected step returns the detector to idle. If that cycle is 155h/AAh, it counts as a new first step.
- R8: A `ram_wr` strobe without `cmd_wr` returns the detector to idle, so a sequence interrupted by a RAM write yields no command.
- R9: A `cmd_wr` strobe while `busy` is high is ignored. It neither advances nor resets the step, and it yields no pulse.
- R10: Matching compares all 9 address bits and all 8 data bits. A third pair at 055h/33h yields nothing, and a first pair at 055h/AAh does not unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | One-cycle strobe for a pseudo-write (nonvolatile, chip and write enables all low) |
| ram_wr | input | 1 | One-cycle strobe for an ordinary RAM write |
| busy | input | 1 | High while a store or recall is in progress |
| addr | input | 9 | Address of the write cycle |
| data | input | 8 | Data of the write cycle |
| store_go | output | 1 | Single-cycle pulse: start a store |
| autostore_arm | output | 1 | Single-cycle pulse: enable the automatic store |
| autostore_disarm | output | 1 | Single-cycle pulse: disable the automatic store |

## Verification
Each command pulse comes from a register. It is high during the single cycle that follows the clock edge which sampled the third matching strobe. The bench drives every strobe for exactly one cycle from a falling edge, then samples the outputs at the next falling edge, which falls inside the pulse cycle. It samples once more a cycle later to confirm the pulse has ended. Cycles that must not produce a command are checked at the same falling edge. This shows that a reset step, an ignored busy cycle or a RAM write leaves nothing on the outputs.

// File: rtl/nv_cmd_pkg.sv
package nv_cmd_pkg;
    typedef enum logic [1:0] {
        STEP_IDLE = 2'd0,
        STEP_ONE  = 2'd1,
        STEP_TWO  = 2'd2
    } step_e;

    localparam int NUM_OPS  = 3;
    localparam int OP_STORE = 0;
    localparam int OP_ARM   = 1;
    localparam int OP_DISARM = 2;
endpackage

// File: rtl/nv_cmd_match.sv
module nv_cmd_match #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8,
    parameter int N_OPS  = 3,
    parameter logic [ADDR_W-1:0] KEY_A1 = 9'h155,
    parameter logic [DATA_W-1:0] KEY_D1 = 8'hAA,
    parameter logic [ADDR_W-1:0] KEY_A2 = 9'h0AA,
    parameter logic [DATA_W-1:0] KEY_D2 = 8'h55,
    parameter logic [N_OPS*DATA_W-1:0] OP_CODES = 24'hCD_CC_33
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              hit_first,
    output logic              hit_second,
    output logic [N_OPS-1:0]  hit_op
);
    logic op_addr_ok;

    always_comb begin
        hit_first  = (addr == KEY_A1) && (data == KEY_D1);
        hit_second = (addr == KEY_A2) && (data == KEY_D2);
        op_addr_ok = (addr == KEY_A1);
    end

    for (genvar i = 0; i < N_OPS; i++) begin : g_op
        assign hit_op[i] = op_addr_ok && (data == OP_CODES[i*DATA_W +: DATA_W]);
    end
endmodule

// File: rtl/nv_cmd_fsm.sv
module nv_cmd_fsm
    import nv_cmd_pkg::*;
#(
    parameter int N_OPS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic             ram_wr,
    input  logic             busy,
    input  logic             hit_first,
    input  logic             hit_second,
    input  logic [N_OPS-1:0] hit_op,
    output logic [N_OPS-1:0] op_pulse
);
    typedef struct packed {
        step_e            step;
        logic [N_OPS-1:0] pulse;
    } fsm_s;

    fsm_s st_d, st_q;
    logic take;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = '0;
        take       = cmd_wr && !busy;
        if (take) begin
            unique case (st_q.step)
                STEP_ONE: begin
                    if (hit_second)     st_d.step = STEP_TWO;
                    else if (hit_first) st_d.step = STEP_ONE;
                    else                st_d.step = STEP_IDLE;
                end
                STEP_TWO: begin
                    if (|hit_op) begin
                        st_d.pulse = hit_op;
                        st_d.step  = STEP_IDLE;
                    end else if (hit_first) begin
                        st_d.step = STEP_ONE;
                    end else begin
                        st_d.step = STEP_IDLE;
                    end
                end
                default: begin
                    st_d.step = hit_first ? STEP_ONE : STEP_IDLE;
                end
            endcase
        end else if (ram_wr && !cmd_wr) begin
            st_d.step = STEP_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.step  <= STEP_IDLE;
            st_q.pulse <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign op_pulse = st_q.pulse;
endmodule

// File: rtl/nv_cmd_detect.sv
module nv_cmd_detect
    import nv_cmd_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              ram_wr,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              store_go,
    output logic              autostore_arm,
    output logic              autostore_disarm
);
    localparam logic [NUM_OPS*DATA_W-1:0] OPS =
        {DATA_W'(8'hCD), DATA_W'(8'hCC), DATA_W'(8'h33)};

    logic               hit_first;
    logic               hit_second;
    logic [NUM_OPS-1:0] hit_op;
    logic [NUM_OPS-1:0] op_pulse;

    nv_cmd_match #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .N_OPS    (NUM_OPS),
        .KEY_A1   (ADDR_W'(9'h155)),
        .KEY_D1   (DATA_W'(8'hAA)),
        .KEY_A2   (ADDR_W'(9'h0AA)),
        .KEY_D2   (DATA_W'(8'h55)),
        .OP_CODES (OPS)
    ) u_match (
        .addr       (addr),
        .data       (data),
        .hit_first  (hit_first),
        .hit_second (hit_second),
        .hit_op     (hit_op)
    );

    nv_cmd_fsm #(
        .N_OPS (NUM_OPS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .ram_wr     (ram_wr),
        .busy       (busy),
        .hit_first  (hit_first),
        .hit_second (hit_second),
        .hit_op     (hit_op),
        .op_pulse   (op_pulse)
    );

    assign store_go         = op_pulse[OP_STORE];
    assign autostore_arm    = op_pulse[OP_ARM];
    assign autostore_disarm = op_pulse[OP_DISARM];
endmodule

// File: rtl/nv_cmd_detect_chk.sv
module nv_cmd_detect_chk #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_wr,
    input logic              ram_wr,
    input logic              busy,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] data,
    input logic              store_go,
    input logic              autostore_arm,
    input logic              autostore_disarm
);
    logic op_cycle;
    assign op_cycle = cmd_wr && !busy && (addr == ADDR_W'(9'h155));

    p_one_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({store_go, autostore_arm, autostore_disarm}));

    p_store_short_r6: assert property (@(posedge clk) disable iff (!rst_n)
        store_go |=> !store_go);

    p_store_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(store_go) |-> $past(op_cycle && data == DATA_W'(8'h33)));

    p_arm_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(autostore_arm) |-> $past(op_cycle && data == DATA_W'(8'hCC)));

    p_disarm_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(autostore_disarm) |-> $past(op_cycle && data == DATA_W'(8'hCD)));

    p_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> !(store_go || autostore_arm || autostore_disarm));

    p_ram_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_wr && !cmd_wr) |=> !(store_go || autostore_arm || autostore_disarm));
endmodule

bind nv_cmd_detect nv_cmd_detect_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cmd_wr           (cmd_wr),
    .ram_wr           (ram_wr),
    .busy             (busy),
    .addr             (addr),
    .data             (data),
    .store_go         (store_go),
    .autostore_arm    (autostore_arm),
    .autostore_disarm (autostore_disarm)
);

// File: tb/test_nv_cmd_detect.sv
`timescale 1ns/1ps
module test_nv_cmd_detect;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic       ram_wr = 1'b0;
    logic       busy = 1'b0;
    logic [8:0] addr = '0;
    logic [7:0] data = '0;
    logic       store_go, autostore_arm, autostore_disarm;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    nv_cmd_detect i_nv_cmd_detect (
        .clk              (clk),
        .rst_n            (rst_n),
        .cmd_wr           (cmd_wr),
        .ram_wr           (ram_wr),
        .busy             (busy),
        .addr             (addr),
        .data             (data),
        .store_go         (store_go),
        .autostore_arm    (autostore_arm),
        .autostore_disarm (autostore_disarm)
    );

    // Output bits packed as {disarm, arm, store}
    localparam logic [2:0] NONE = 3'b000;
    localparam logic [2:0] STO  = 3'b001;
    localparam logic [2:0] ARM  = 3'b010;
    localparam logic [2:0] DIS  = 3'b100;

    function automatic logic [2:0] outs();
        return {autostore_disarm, autostore_arm, store_go};
    endfunction

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs actual %b expected %b", tag, act, exp);
        end
    endtask

    // One-cycle command strobe; outputs sampled at the following falling edge.
    task automatic cmd(input logic [8:0] a, input logic [7:0] d, input logic bsy,
                       input string tag, input logic [2:0] exp);
        @(negedge clk);
        cmd_wr = 1'b1; busy = bsy; addr = a; data = d;
        @(negedge clk);
        cmd_wr = 1'b0; busy = 1'b0;
        check(tag, outs(), exp);
    endtask

    task automatic ram_write(input string tag);
        @(negedge clk);
        ram_wr = 1'b1; addr = 9'h155; data = 8'hAA;
        @(negedge clk);
        ram_wr = 1'b0;
        check(tag, outs(), NONE);
    endtask

    task automatic pulse_gone(input string tag);
        @(negedge clk);
        check(tag, outs(), NONE);
    endtask

    task automatic t_reset();
        check("R1 reset outputs", outs(), NONE);
        cmd(9'h155, 8'h33, 1'b0, "R1 op pair alone after reset", NONE);
    endtask

    task automatic t_store();
        cmd(9'h155, 8'hAA, 1'b0, "R2 first step quiet", NONE);
        @(negedge clk); @(negedge clk);
        cmd(9'h0AA, 8'h55, 1'b0, "R2 second step quiet", NONE);
        cmd(9'h155, 8'h33, 1'b0, "R3 store pulse", STO);
        pulse_gone("R6 store pulse one cycle");
        cmd(9'h155, 8'h33, 1'b0, "R6 idle after command", NONE);
    endtask

    task automatic t_arm_disarm();
        cmd(9'h155, 8'hAA, 1'b0, "R4 step1", NONE);
        cmd(9'h0AA, 8'h55, 1'b0, "R4 step2", NONE);
        cmd(9'h155, 8'hCC, 1'b0, "R4 arm pulse", ARM);
        pulse_gone("R6 arm pulse one cycle");
        cmd(9'h155, 8'hAA, 1'b0, "R5 step1", NONE);
        cmd(9'h0AA, 8'h55, 1'b0, "R5 step2", NONE);
        cmd(9'h155, 8'hCD, 1'b0, "R5 disarm pulse", DIS);
        pulse_gone("R6 disarm pulse one cycle");
    endtask

    task automatic t_mismatch();
        cmd(9'h155, 8'hAA, 1'b0, "R7 a step1", NONE);
        cmd(9'h0AA, 8'h56, 1'b0, "R7 a bad step2", NONE);
        cmd(9'h155, 8'h33, 1'b0, "R7 a no command after mismatch", NONE);
        cmd(9'h155, 8'hAA, 1'b0, "R7 b step1", NONE);
        cmd(9'h155, 8'hAA, 1'b0, "R7 b step1 again", NONE);
        cmd(9'h0AA, 8'h55, 1'b0, "R7 b step2", NONE);
        cmd(9'h155, 8'hCC, 1'b0, "R7 b arm after restart", ARM);
        cmd(9'h155, 8'hAA, 1'b0, "R7 c step1", NONE);
        cmd(9'h0AA, 8'h55, 1'b0, "R7 c step2", NONE);
        cmd(9'h155, 8'hAA, 1'b0, "R7 c restart at step3", NONE);
        cmd(9'h0AA, 8'h55, 1'b0, "R7 c step2", NONE);
        cmd(9'h155, 8'hCD, 1'b0, "R7 c disarm", DIS);
        cmd(9'h155, 8'hAA, 1'b0, "R7 d step1", NONE);
        cmd(9'h0AA, 8'h55, 1'b0, "R7 d step2", NONE);
        cmd(9'h155, 8'h00, 1'b0, "R7 d bad op", NONE);
        cmd(9'h155, 8'h33, 1'b0, "R7 d no store after bad op", NONE);
    endtask

    task automatic t_ram();
        cmd(9'h155, 8'hAA, 1'b0, "R8 step1", NONE);
        ram_write("R8 ram write quiet");
        cmd(9'h0AA, 8'h55, 1'b0, "R8 step2 after ram write", NONE);
        cmd(9'h155, 8'h33, 1'b0, "R8 no store after ram write", NONE);
        cmd(9'h155, 8'hAA, 1'b0, "R8 step1 fresh", NONE);
        cmd(9'h0AA, 8'h55, 1'b0, "R8 step2 fresh", NONE);
        ram_write("R8 ram write at step3");
        cmd(9'h155, 8'h33, 1'b0, "R8 no store after late ram write", NONE);
    endtask

    task automatic t_busy();
        cmd(9'h155, 8'hAA, 1'b1, "R9 busy step1 ignored", NONE);
        cmd(9'h0AA, 8'h55, 1'b0, "R9 step2 no unlock", NONE);
        cmd(9'h155, 8'h33, 1'b0, "R9 no store", NONE);
        cmd(9'h155, 8'hAA, 1'b0, "R9 step1", NONE);
        cmd(9'h000, 8'h00, 1'b1, "R9 busy garbage ignored", NONE);
        cmd(9'h0AA, 8'h55, 1'b0, "R9 step2 kept", NONE);
        cmd(9'h155, 8'hCC, 1'b1, "R9 busy op ignored", NONE);
        cmd(9'h155, 8'h33, 1'b0, "R9 store after busy", STO);
    endtask

    task automatic t_addr();
        cmd(9'h155, 8'hAA, 1'b0, "R10 step1", NONE);
        cmd(9'h0AA, 8'h55, 1'b0, "R10 step2", NONE);
        cmd(9'h055, 8'h33, 1'b0, "R10 wrong op address", NONE);
        cmd(9'h055, 8'hAA, 1'b0, "R10 wrong step1 address", NONE);
        cmd(9'h0AA, 8'h55, 1'b0, "R10 step2 without step1", NONE);
        cmd(9'h155, 8'h33, 1'b0, "R10 no store", NONE);
        cmd(9'h155, 8'hAA, 1'b0, "R10 step1", NONE);
        cmd(9'h1AA, 8'h55, 1'b0, "R10 step2 high bit set", NONE);
        cmd(9'h155, 8'hCD, 1'b0, "R10 no disarm", NONE);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_store();
        t_arm_disarm();
        t_mismatch();
        t_ram();
        t_busy();
        t_addr();
        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule